// File: doc/BRIEF.md
# Reference Window Line Streamer

This block serves a motion-compensated interpolator with reference pixels. It takes one request describing a block (its width, its height and its top-left position in the picture). It then reads the enlarged window the interpolation filter needs straight out of a synchronous frame memory, one line at a time. Each pixel goes onto a valid/ready output stream in the cycle after its read. No copy of the block is ever held inside the block itself.

For a request of W×H at (x, y), the window spans W+5 columns and H+5 lines and begins two pixels left of and two lines above the block. Window coordinates that fall outside the picture are clamped to the nearest edge pixel. Each line is handled in two steps. A setup cycle resolves the vertical picture coordinate and the line's base address. A run of reads then walks the columns. Output backpressure holds the read side, so that every window pixel leaves exactly once.

Top module: `ref_window_streamer`

## Requirements
- R1: `req_ready` is high only while the block is idle. A request is taken on a cycle with `req_valid` and `req_ready` both high. A `req_valid` raised while busy is ignored: it changes neither the current window nor the output after it.
- R2: For a request W×H at (x, y), the output carries (W+5)×(H+5) pixels in raster order: lines from y-2 to y+H+2, and within each line columns from x-2 to x+W+2, left to right.
- R3: A window column below 0 or above PIC_W-1 reads column 0 or PIC_W-1. A window line below 0 or above PIC_H-1 reads line 0 or PIC_H-1.
- R4: Every read asserts `mem_rd` with `mem_addr` = line × PIC_W + column, and the address is always below PIC_W × PIC_H.
- R5: The memory answers one cycle after `mem_rd`. `out_valid` rises in that cycle, and `out_pix` is the memory word at the address that was read.
- R6: While `out_valid` is high and `out_ready` low, no read is issued. The memory output holds, so no pixel is lost or repeated under any stall pattern.
- R7: `done` is high for exactly one cycle: the cycle after the last window pixel is accepted. The block is idle in that cycle.
- R8: `out_eol` is high with the last pixel of each window line and low with every other pixel.
- R9: After reset, `req_ready` is 1 and `out_valid`, `done` and `mem_rd` are 0.
- R10: Supported block sizes are 4×4, 4×8, 8×4, 8×8, 16×8, 8×16 and 16×16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block idle, request can be taken |
| req_w | input | SZ_W | Block width in pixels |
| req_h | input | SZ_W | Block height in lines |
| req_x | input | $clog2(PIC_W) | Block left column |
| req_y | input | $clog2(PIC_H) | Block top line |
| mem_rd | output | 1 | Frame memory read enable |
| mem_addr | output | $clog2(PIC_W*PIC_H) | Frame memory word address |
| mem_data | input | PIX_W | Frame memory read data, one cycle after `mem_rd`, held otherwise |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Output pixel accepted |
| out_pix | output | PIX_W | Output pixel |
| out_eol | output | 1 | Last pixel of a window line |
| done | output | 1 | One-cycle pulse after the window's last pixel |

## Verification
The test requests cover every supported size at interior positions and at positions that push the window past each picture edge. This separates correct clamping on each side from a window offset error or a row/column swap. Each size runs with a free output and again with a repeating stall. Pixel mismatches that appear only under stall point at the hold logic rather than the address path. One directed run pokes a request mid-window and then confirms that the output stays silent after `done`.

// File: rtl/ref_window_streamer.sv
module ref_window_streamer #(
  parameter int PIC_W = 32,
  parameter int PIC_H = 24,
  parameter int PIX_W = 8,
  parameter int SZ_W  = 5
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             req_valid,
  output logic                             req_ready,
  input  logic [SZ_W-1:0]                  req_w,
  input  logic [SZ_W-1:0]                  req_h,
  input  logic [$clog2(PIC_W)-1:0]         req_x,
  input  logic [$clog2(PIC_H)-1:0]         req_y,
  output logic                             mem_rd,
  output logic [$clog2(PIC_W*PIC_H)-1:0]   mem_addr,
  input  logic [PIX_W-1:0]                 mem_data,
  output logic                             out_valid,
  input  logic                             out_ready,
  output logic [PIX_W-1:0]                 out_pix,
  output logic                             out_eol,
  output logic                             done
);
  localparam int XW = $clog2(PIC_W);
  localparam int YW = $clog2(PIC_H);
  localparam int AW = $clog2(PIC_W*PIC_H);
  localparam int CW = ((XW > YW) ? XW : YW) + 2;

  typedef enum logic [1:0] {S_IDLE, S_ROW, S_RUN, S_LAST} st_t;
  st_t state;

  logic [SZ_W-1:0]        blk_w, blk_h, col, row;
  logic signed [CW-1:0]   org_x, org_y, cur_x, cur_y;
  logic [AW-1:0]          row_base;
  logic                   pend, pend_eol;
  logic                   issue, last_col, last_row;

  function automatic logic [XW-1:0] clamp_x(input logic signed [CW-1:0] v);
    if (v < 0) return '0;
    else if (v > $signed(CW'(PIC_W-1))) return XW'(PIC_W-1);
    else return v[XW-1:0];
  endfunction

  function automatic logic [YW-1:0] clamp_y(input logic signed [CW-1:0] v);
    if (v < 0) return '0;
    else if (v > $signed(CW'(PIC_H-1))) return YW'(PIC_H-1);
    else return v[YW-1:0];
  endfunction

  assign cur_x     = org_x + $signed(CW'(col));
  assign cur_y     = org_y + $signed(CW'(row));
  assign last_col  = (col == blk_w + SZ_W'(4));
  assign last_row  = (row == blk_h + SZ_W'(4));
  assign issue     = (state == S_RUN) && (!pend || out_ready);

  assign req_ready = (state == S_IDLE);
  assign mem_rd    = issue;
  assign mem_addr  = row_base + AW'(clamp_x(cur_x));
  assign out_valid = pend;
  assign out_pix   = mem_data;
  assign out_eol   = pend_eol;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      pend     <= 1'b0;
      pend_eol <= 1'b0;
      done     <= 1'b0;
      blk_w    <= '0;
      blk_h    <= '0;
      col      <= '0;
      row      <= '0;
      org_x    <= '0;
      org_y    <= '0;
      row_base <= '0;
    end else begin
      done <= 1'b0;
      if (pend && out_ready) pend <= 1'b0;
      if (issue) begin
        pend     <= 1'b1;
        pend_eol <= last_col;
      end
      case (state)
        S_IDLE: if (req_valid) begin
          blk_w <= req_w;
          blk_h <= req_h;
          org_x <= $signed(CW'(req_x)) - $signed(CW'(2));
          org_y <= $signed(CW'(req_y)) - $signed(CW'(2));
          row   <= '0;
          state <= S_ROW;
        end
        S_ROW: begin
          row_base <= AW'(clamp_y(cur_y)) * AW'(PIC_W);
          col      <= '0;
          state    <= S_RUN;
        end
        S_RUN: if (issue) begin
          col <= col + SZ_W'(1);
          if (last_col) begin
            if (last_row) state <= S_LAST;
            else begin
              row   <= row + SZ_W'(1);
              state <= S_ROW;
            end
          end
        end
        default: if (pend && out_ready) begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
      endcase
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !out_valid);
  p_addr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mem_addr < AW'(PIC_W*PIC_H)));
  p_read_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> out_valid);
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !mem_rd);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && !out_valid));
endmodule

// File: tb/ref_window_streamer_tb_top.sv
module ref_window_streamer_tb_top;
  localparam int PIC_W = 32;
  localparam int PIC_H = 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [4:0] req_w = '0, req_h = '0, req_x = '0, req_y = '0;
  logic       mem_rd;
  logic [9:0] mem_addr;
  logic [7:0] mem_data = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_pix;
  logic       out_eol;
  logic       done;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] pixf(input int a);
    return 8'((a * 13) ^ (a >> 4));
  endfunction

  always @(posedge clk) if (mem_rd) mem_data <= pixf(int'(mem_addr));

  ref_window_streamer #(.PIC_W(PIC_W), .PIC_H(PIC_H), .PIX_W(8), .SZ_W(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_w(req_w), .req_h(req_h), .req_x(req_x), .req_y(req_y),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
    .out_eol(out_eol), .done(done));

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int clampi(input int v, input int hi);
    return (v < 0) ? 0 : ((v > hi) ? hi : v);
  endfunction

  // each entry: {w, h, x, y}, one byte each
  localparam logic [31:0] VEC [8] = '{
    32'h04_04_0A_0A, 32'h04_08_00_00, 32'h08_04_1C_14, 32'h08_08_01_01,
    32'h10_08_10_05, 32'h08_10_18_08, 32'h10_10_00_08, 32'h10_10_10_07 };

  task automatic run_block(input int w, input int h, input int x, input int y,
                           input bit stall, input bit poke);
    int total = (w + 5) * (h + 5);
    int n = 0;
    int guard = 0;
    @(negedge clk);
    req_w = 5'(w); req_h = 5'(h); req_x = 5'(x); req_y = 5'(y);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (n < total && guard < 20000) begin
      @(negedge clk);
      guard++;
      out_ready = stall ? ((cyc % 3) != 1) : 1'b1;
      if (poke && n == 5) begin
        req_valid = 1'b1; req_w = 5'd16; req_h = 5'd16; req_x = 5'd3; req_y = 5'd3;
      end else req_valid = 1'b0;
      #1;
      if (poke && n == 5) chk(req_ready == 1'b0, "R1 busy ready", req_ready, 0);
      if (out_valid && out_ready) begin
        int r = n / (w + 5);
        int c = n % (w + 5);
        int ey = clampi(y - 2 + r, PIC_H - 1);
        int ex = clampi(x - 2 + c, PIC_W - 1);
        chk(out_pix == pixf(ey * PIC_W + ex), "R2/R3/R5 pixel", out_pix, pixf(ey * PIC_W + ex));
        chk(out_eol == (c == w + 4), "R8 eol", out_eol, (c == w + 4));
        n++;
      end else if (out_valid) begin
        chk(mem_rd == 1'b0, "R6 stall read", mem_rd, 0);
      end
    end
    req_valid = 1'b0;
    chk(n == total, "R2 count", n, total);
    @(negedge clk); #1;
    chk(done == 1'b1, "R7 done pulse", done, 1);
    chk(req_ready == 1'b1, "R7 idle at done", req_ready, 1);
    @(negedge clk); #1;
    chk(done == 1'b0, "R7 done width", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready == 1'b1 && out_valid == 1'b0 && done == 1'b0 && mem_rd == 1'b0,
        "R9 reset outputs", {req_ready, out_valid, done, mem_rd}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(req_ready == 1'b1 && out_valid == 1'b0, "R9 after reset",
        {req_ready, out_valid}, 2'b10);

    // R10: each supported size, free-running then stalled output
    for (int i = 0; i < 8; i++) begin
      run_block(int'(VEC[i][31:24]), int'(VEC[i][23:16]),
                int'(VEC[i][15:8]), int'(VEC[i][7:0]), 1'b0, 1'b0);
      run_block(int'(VEC[i][31:24]), int'(VEC[i][23:16]),
                int'(VEC[i][15:8]), int'(VEC[i][7:0]), 1'b1, 1'b0);
    end

    // R1: request raised while busy must be ignored
    run_block(4, 4, 31, 23, 1'b0, 1'b1);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); #1;
      chk(out_valid == 1'b0 && mem_rd == 1'b0, "R1 no extra output",
          {out_valid, mem_rd}, 0);
    end

    // R3: far corner with stalls, R4 via pixel match
    run_block(16, 16, 31, 23, 1'b1, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule